// File: doc/BRIEF.md
# Parallel Flash Command Interface

This block is the device-side command logic of a byte-wide parallel flash memory. The active-low chip-enable, output-enable and write-enable strobes are brought into the system clock domain through two-flop synchronizers, and strobe edges are detected from the synchronized samples. A write is a rising edge of write-enable while chip-enable is low and output-enable is high. The byte on the data bus at that edge is taken as a command, or as program data when a program setup came just before it. Writes are only accepted while the high-voltage-valid input is asserted. When that input is low the block is held in plain array-read mode.

Some commands take one write: array read, signature read, erase verify and program verify. Others take two. Erase needs the erase code written twice in a row. Program is a setup code followed by an address/data write. Reset is the reset code written twice, and it abandons any program or erase. The address for an operation is captured on the falling edge of write-enable and the data on the rising edge. A built-in stop timer times each program or erase pulse, and the pulse then acts on a small behavioural array. Programming clears bits (the new byte is the old byte AND the data). Erasing sets every byte to FFh.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in array-read mode, `out_sel` is 0 (live-address array), and every array byte reads FFh.
- R2: `dq_oe` is 1 only while the synchronized chip-enable and output-enable are low and write-enable is high. With chip-enable high or output-enable high it is 0 and `dq_o` is 0.
- R3: While `vpp_ok` is low, writes are ignored and the block is in array-read mode. Dropping `vpp_ok` during a program operation cancels it and leaves the array unchanged.
- R4: The command codes are 00h array read (`out_sel` 0) and 90h signature read (`out_sel` 1). Any code other than 00h, 90h, 20h, A0h, 40h, C0h or FFh selects array read.
- R5: In signature mode a read with address bit 0 clear returns 31h, and a read with address bit 0 set returns B4h.
- R6: Program is 40h followed by a second write. The address is taken at the write-enable falling edge and the data at the rising edge. That rising edge produces exactly one one-cycle `prog_go` pulse. After PROG_CYC cycles, the addressed byte becomes old AND data.
- R7: Program verify (C0h) sets `out_sel` to 2 and reads the array at the address latched by the last program write, whatever is on the address bus.
- R8: Erase starts only on 20h written on two consecutive writes. It gives one `erase_go` pulse, and after ERASE_CYC cycles every byte reads FFh.
- R9: If 20h is followed by any other byte, no erase starts and that byte is decoded as a fresh command.
- R10: Erase verify (A0h) latches the address from its write-enable falling edge, sets `out_sel` to 2 and reads that byte. An erase still being timed is stopped with the array unchanged.
- R11: FFh written twice in a row returns to array read and cancels a pending program or erase with no array change. A single FFh followed by another code decodes that code.
- R12: A write-enable rising edge with chip-enable high is not taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| vpp_ok | input | 1 | High-voltage-valid, gates all writes |
| addr | input | AW | Byte address |
| din | input | 8 | Data bus input (command or program data) |
| dq_o | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable (0 = high impedance) |
| out_sel | output | 2 | Output mux select: 0 live array, 1 signature, 2 latched-address array |
| prog_go | output | 1 | One-cycle start pulse of the program timer |
| erase_go | output | 1 | One-cycle start pulse of the erase timer |

## Verification
Several rules are checked by the assertions on every cycle. A low `vpp_ok` forces read mode. Chip-enable held high keeps the bus undriven. Each `erase_go` pulse comes straight out of the erase setup state, and each `prog_go` pulse comes straight out of program setup. The two timer completions never coincide, an erase completion leaves the array erased, and a stop request ends an erase pulse. The bench scenarios cover the rest. These are the command sequences and their ordering: a broken erase pair, a single reset code, and abort or erase-verify arriving mid-pulse. They also include the address being captured on the falling edge rather than the rising edge, and the array contents after program and erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_READ  = 8'h00;
    localparam logic [7:0] CMD_SIG   = 8'h90;
    localparam logic [7:0] CMD_ERASE = 8'h20;
    localparam logic [7:0] CMD_EVFY  = 8'hA0;
    localparam logic [7:0] CMD_PROG  = 8'h40;
    localparam logic [7:0] CMD_PVFY  = 8'hC0;
    localparam logic [7:0] CMD_RST   = 8'hFF;

    localparam logic [7:0] SIG_MAKER  = 8'h31;
    localparam logic [7:0] SIG_DEVICE = 8'hB4;

    localparam logic [1:0] SEL_LIVE  = 2'd0;
    localparam logic [1:0] SEL_SIG   = 2'd1;
    localparam logic [1:0] SEL_LATCH = 2'd2;

    localparam int STB_CE = 0;
    localparam int STB_OE = 1;
    localparam int STB_WE = 2;
    localparam int NSTB   = 3;

    typedef enum logic [3:0] {
        M_READ, M_SIG, M_ERS_SETUP, M_ERASE, M_ERS_VFY,
        M_PRG_SETUP, M_PROGRAM, M_PRG_VFY, M_RST_SETUP
    } mode_t;

    typedef enum logic [1:0] { K_IDLE, K_PRG, K_ERS } tkind_t;

    function automatic mode_t decode_cmd(input logic [7:0] c);
        case (c)
            CMD_SIG:   return M_SIG;
            CMD_ERASE: return M_ERS_SETUP;
            CMD_EVFY:  return M_ERS_VFY;
            CMD_PROG:  return M_PRG_SETUP;
            CMD_PVFY:  return M_PRG_VFY;
            CMD_RST:   return M_RST_SETUP;
            default:   return M_READ;
        endcase
    endfunction

endpackage

// File: rtl/fci_sync.sv
module fci_sync #(
    parameter int NS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] async_i,
    output logic [NS-1:0] lvl_o,
    output logic [NS-1:0] rise_o,
    output logic [NS-1:0] fall_o
);
    logic [NS-1:0] s0_q, s1_q, s2_q;

    for (genvar i = 0; i < NS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s0_q[i] <= 1'b1;
                s1_q[i] <= 1'b1;
                s2_q[i] <= 1'b1;
            end else begin
                s0_q[i] <= async_i[i];
                s1_q[i] <= s0_q[i];
                s2_q[i] <= s1_q[i];
            end
        end
        assign lvl_o[i]  = s1_q[i];
        assign rise_o[i] = s1_q[i] & ~s2_q[i];
        assign fall_o[i] = ~s1_q[i] & s2_q[i];
    end
endmodule

// File: rtl/fci_timer.sv
module fci_timer
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prg_i,
    input  logic start_ers_i,
    input  logic stop_ers_i,
    input  logic abort_i,
    output logic done_prg_o,
    output logic done_ers_o
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1) + 1;
    localparam logic [CW-1:0] PLIM = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] ELIM = CW'(ERASE_CYC - 1);

    typedef struct packed {
        tkind_t        kind;
        logic [CW-1:0] cnt;
    } tstate_t;

    tstate_t ts_d, ts_q;
    logic    hit;

    always_comb begin
        ts_d       = ts_q;
        done_prg_o = 1'b0;
        done_ers_o = 1'b0;
        hit = (ts_q.kind == K_PRG && ts_q.cnt == PLIM) ||
              (ts_q.kind == K_ERS && ts_q.cnt == ELIM);
        if (abort_i || (stop_ers_i && ts_q.kind == K_ERS)) begin
            ts_d.kind = K_IDLE;
        end else if (start_prg_i || start_ers_i) begin
            ts_d.kind = start_ers_i ? K_ERS : K_PRG;
            ts_d.cnt  = '0;
        end else if (ts_q.kind != K_IDLE) begin
            if (hit) begin
                done_prg_o = (ts_q.kind == K_PRG);
                done_ers_o = (ts_q.kind == K_ERS);
                ts_d.kind  = K_IDLE;
            end else begin
                ts_d.cnt = ts_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '{kind: K_IDLE, cnt: '0};
        else        ts_q <= ts_d;
    end

    a_r11_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_prg_o, done_ers_o}));
    a_r10_stop_ends_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ers_i && ts_q.kind == K_ERS) |=> (ts_q.kind == K_IDLE));
endmodule

// File: rtl/fci_array.sv
module fci_array #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prg_en_i,
    input  logic [AW-1:0] prg_addr_i,
    input  logic [7:0]    prg_data_i,
    input  logic          ers_en_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (ers_en_i) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (prg_en_i) begin
            mem_q[prg_addr_i] <= mem_q[prg_addr_i] & prg_data_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    a_r8_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en_i |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 6,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          vpp_ok,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dq_o,
    output logic          dq_oe,
    output logic [1:0]    out_sel,
    output logic          prog_go,
    output logic          erase_go
);
    typedef struct packed {
        mode_t         mode;
        logic [AW-1:0] lat_addr;
        logic [AW-1:0] fall_addr;
        logic [7:0]    lat_data;
        logic          go_prg;
        logic          go_ers;
        logic          stop_ers;
        logic          abort;
    } st_t;

    st_t st_d, st_q;

    logic [NSTB-1:0] lvl, rise, fall;
    logic            rise_ok, fall_ok, do_decode;
    logic            done_prg, done_ers;
    logic [AW-1:0]   raddr;
    logic [7:0]      rdata, out_val;

    fci_sync #(.NS(NSTB)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({we_n, oe_n, ce_n}),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    assign rise_ok = rise[STB_WE] & ~lvl[STB_CE] & lvl[STB_OE] & vpp_ok;
    assign fall_ok = fall[STB_WE] & ~lvl[STB_CE] & lvl[STB_OE];

    always_comb begin
        st_d          = st_q;
        st_d.go_prg   = 1'b0;
        st_d.go_ers   = 1'b0;
        st_d.stop_ers = 1'b0;
        st_d.abort    = 1'b0;
        do_decode     = 1'b0;
        if (fall_ok) st_d.fall_addr = addr;
        if (!vpp_ok) begin
            st_d.mode  = M_READ;
            st_d.abort = 1'b1;
        end else if (rise_ok) begin
            case (st_q.mode)
                M_PRG_SETUP: begin
                    st_d.lat_addr = st_q.fall_addr;
                    st_d.lat_data = din;
                    st_d.mode     = M_PROGRAM;
                    st_d.go_prg   = 1'b1;
                end
                M_ERS_SETUP: begin
                    if (din == CMD_ERASE) begin
                        st_d.mode   = M_ERASE;
                        st_d.go_ers = 1'b1;
                    end else begin
                        do_decode = 1'b1;
                    end
                end
                M_RST_SETUP: begin
                    if (din == CMD_RST) begin
                        st_d.mode  = M_READ;
                        st_d.abort = 1'b1;
                    end else begin
                        do_decode = 1'b1;
                    end
                end
                default: do_decode = 1'b1;
            endcase
            if (do_decode) begin
                st_d.mode = decode_cmd(din);
                if (din == CMD_EVFY) begin
                    st_d.lat_addr = st_q.fall_addr;
                    st_d.stop_ers = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_READ, lat_addr: '0, fall_addr: '0, lat_data: '0,
                      go_prg: 1'b0, go_ers: 1'b0, stop_ers: 1'b0, abort: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    fci_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start_prg_i(st_q.go_prg), .start_ers_i(st_q.go_ers),
        .stop_ers_i(st_q.stop_ers), .abort_i(st_q.abort),
        .done_prg_o(done_prg), .done_ers_o(done_ers)
    );

    fci_array #(.AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .prg_en_i(done_prg), .prg_addr_i(st_q.lat_addr), .prg_data_i(st_q.lat_data),
        .ers_en_i(done_ers),
        .raddr_i(raddr), .rdata_o(rdata)
    );

    always_comb begin
        case (st_q.mode)
            M_SIG:                                   out_sel = SEL_SIG;
            M_ERS_VFY, M_PRG_VFY, M_ERASE, M_PROGRAM: out_sel = SEL_LATCH;
            default:                                 out_sel = SEL_LIVE;
        endcase
        raddr   = (out_sel == SEL_LATCH) ? st_q.lat_addr : addr;
        out_val = (out_sel == SEL_SIG) ? (addr[0] ? SIG_DEVICE : SIG_MAKER) : rdata;
        dq_oe   = ~lvl[STB_CE] & ~lvl[STB_OE] & lvl[STB_WE];
        dq_o    = dq_oe ? out_val : 8'h00;
    end

    assign prog_go  = st_q.go_prg;
    assign erase_go = st_q.go_ers;

    a_r3_vpp_forces_read: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_ok |=> (st_q.mode == M_READ));
    a_r2_ce_high_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n) && $past(ce_n, 2)) |-> !dq_oe);
    a_r8_erase_from_pair: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> (st_q.mode == M_ERASE && $past(st_q.mode) == M_ERS_SETUP));
    a_r6_prog_from_setup: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> ($past(st_q.mode) == M_PRG_SETUP));
endmodule

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
    localparam int AW = 6;
    localparam int PC = 64;
    localparam int EC = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp_ok = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dq_o;
    logic dq_oe;
    logic [1:0] out_sel;
    logic prog_go, erase_go;

    int n_chk = 0, n_fail = 0, n_prg = 0, n_ers = 0;
    logic [7:0] model [1 << AW];
    logic finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_if #(.AW(AW), .PROG_CYC(PC), .ERASE_CYC(EC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .vpp_ok(vpp_ok), .addr(addr), .din(din), .dq_o(dq_o), .dq_oe(dq_oe),
        .out_sel(out_sel), .prog_go(prog_go), .erase_go(erase_go)
    );

    always @(posedge clk) begin
        if (prog_go)  n_prg++;
        if (erase_go) n_ers++;
    end

    function automatic logic [7:0] sig_val(input logic [AW-1:0] a);
        return a[0] ? 8'hB4 : 8'h31;
    endfunction

    function automatic bit is_known(input logic [7:0] c);
        return c == 8'h00 || c == 8'h90 || c == 8'h20 || c == 8'hA0 ||
               c == 8'h40 || c == 8'hC0 || c == 8'hFF;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_split(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                            input logic [7:0] d);
        ce_n = 1'b0; oe_n = 1'b1; addr = a_fall; din = d;
        cyc(2); we_n = 1'b0;
        cyc(4); addr = a_rise;
        cyc(2); we_n = 1'b1;
        cyc(4); ce_n = 1'b1;
        cyc(2);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_split(a, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        cyc(5);
        v = dq_o;
        oe_n = 1'b1; ce_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        cyc(200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        cyc(3); rst_n = 1'b1; cyc(3);

        // R1 reset state
        check("R1 out_sel", out_sel, 0);
        rd(6'd5, v); check("R1 erased array", v, 8'hFF);

        // R2 output enable
        ce_n = 1'b0; oe_n = 1'b0; cyc(5);
        check("R2 enabled", dq_oe, 1);
        ce_n = 1'b1; cyc(5);
        check("R2 ce high", dq_oe, 0); check("R2 dq zero", dq_o, 0);
        ce_n = 1'b0; oe_n = 1'b1; cyc(5);
        check("R2 oe high", dq_oe, 0);
        ce_n = 1'b1; cyc(3);

        // R4 R5 signature
        wr(0, 8'h90); check("R4 sig sel", out_sel, 1);
        rd(6'd0, v); check("R5 maker", v, 8'h31);
        rd(6'd1, v); check("R5 device", v, 8'hB4);
        wr(0, 8'h00); check("R4 read sel", out_sel, 0);

        // R6 program, address from falling edge
        wr(0, 8'h40); wr_split(6'd3, 6'd9, 8'h5A);
        cyc(PC + 10); model[3] = model[3] & 8'h5A;
        check("R6 one pulse", n_prg, 1);
        // R7 program verify
        wr(0, 8'hC0); check("R7 sel", out_sel, 2);
        rd(6'd20, v); check("R7 latched byte", v, 8'h5A);
        wr(0, 8'h00);
        rd(6'd9, v); check("R6 rise addr untouched", v, 8'hFF);
        rd(6'd3, v); check("R6 programmed", v, 8'h5A);

        // R12 write with ce high ignored
        ce_n = 1'b1; oe_n = 1'b1; din = 8'h90; addr = 0;
        cyc(2); we_n = 1'b0; cyc(4); we_n = 1'b1; cyc(4);
        check("R12 ignored", out_sel, 0);
        rd(6'd0, v); check("R12 array read", v, model[0]);

        // R3 vpp gating
        vpp_ok = 1'b0; wr(0, 8'h90);
        check("R3 ignored", out_sel, 0);
        rd(6'd0, v); check("R3 array read", v, model[0]);
        vpp_ok = 1'b1;
        wr(0, 8'h40); wr(6'd4, 8'h00);
        vpp_ok = 1'b0; cyc(3); vpp_ok = 1'b1; cyc(PC + 10);
        check("R3 sel read", out_sel, 0);
        rd(6'd4, v); check("R3 cancelled", v, 8'hFF);

        // R9 broken erase pair
        wr(0, 8'h20); wr(0, 8'h90);
        check("R9 no erase", n_ers, 0); check("R9 decoded", out_sel, 1);
        rd(6'd1, v); check("R9 sig", v, 8'hB4);

        // R11 reset aborts program; single reset then other code
        wr(0, 8'h40); wr(6'd6, 8'h0F); wr(0, 8'hFF); wr(0, 8'hFF);
        check("R11 read mode", out_sel, 0);
        cyc(PC + 10);
        rd(6'd6, v); check("R11 abort", v, 8'hFF);
        wr(0, 8'hFF); wr(0, 8'h90);
        check("R11 single reset", out_sel, 1);
        rd(6'd0, v); check("R11 sig", v, 8'h31);

        // R10 erase verify stops erase in progress
        wr(0, 8'h20); wr(0, 8'h20); wr(6'd3, 8'hA0);
        check("R10 sel", out_sel, 2);
        rd(6'd40, v); check("R10 latched", v, model[3]);
        cyc(EC + 20); wr(0, 8'h00);
        rd(6'd3, v); check("R10 erase stopped", v, 8'h5A);

        // R8 full erase
        wr(0, 8'h20); wr(0, 8'h20); cyc(EC + 20);
        check("R8 two pulses", n_ers, 2);
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        wr(6'd3, 8'hA0); rd(6'd0, v); check("R8 erased", v, 8'hFF);
        wr(0, 8'h00);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int op;
            logic [AW-1:0] a;
            logic [7:0] d;
            op = $urandom % 3; a = AW'($urandom); d = 8'($urandom);
            if (op == 0) begin
                wr(0, 8'h40); wr(a, d); cyc(PC + 10);
                model[a] = model[a] & d;
                wr(0, 8'h00); rd(a, v); check("R6 random program", v, model[a]);
            end else if (op == 1) begin
                wr(0, 8'h90); rd(a, v); check("R5 random sig", v, sig_val(a));
            end else begin
                if (is_known(d)) d = 8'h55;
                wr(0, d); check("R4 unknown sel", out_sel, 0);
                rd(a, v); check("R4 unknown read", v, model[a]);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule